// File: doc/BRIEF.md
# Watermark-Driven Long-Word Data FIFO

This block is a first-in first-out buffer of 32-bit long words. It sits between a bus-side register and data port and a DMA-style requester. Each cycle it reports whether it is full and whether it is empty. It compares its free space against a programmable 3-bit granularity to produce two alarms. The low alarm means "room to accept more data" and the high alarm means "nearly full, drain me". A mode bit selects which alarm drives the request output. In transmit use the FIFO asks to be filled. In receive use it asks to be drained.

Misuse of the data port is recorded in two sticky error bits. Writing into a full FIFO sets the overflow bit, and reading from an empty one sets the underflow bit. Neither misuse moves a pointer or touches the stored words. Software clears each error bit by writing 1 to it. A dedicated FIFO clear input discards the contents and both error bits and keeps the configuration.

The register port has two locations. Address 0 is status: bit 0 empty, bit 1 full, bit 2 low alarm, bit 3 high alarm, bit 4 overflow, bit 5 underflow. Address 1 is control: bits 2:0 granularity, bit 3 receive mode. Unused bits read 0.

Top module: `wm_fifo`

## Requirements
- R1: After reset the status register reads 0x05 (empty and low alarm), the control register reads 0x00, and `dreq_o` is 1.
- R2: Words leave in the order they were written. `rd_data_o` shows the oldest stored word whenever the FIFO is not empty. A simultaneous read and write on a non-empty FIFO keeps the level unchanged.
- R3: Full (status bit 1, `full_o`) and empty (status bit 0, `empty_o`) follow the level every cycle, with a depth of 64 words, and are never sticky.
- R4: A write while full stores nothing and sets overflow (status bit 4). This holds even when a read happens in the same cycle, and that read still removes one word. Previously stored words are read back intact.
- R5: A read while empty removes nothing and sets underflow (status bit 5). A write in the same cycle is still stored.
- R6: Overflow and underflow stay set until a write to address 0 with a 1 in their bit position. Writing 0 has no effect. A new error in the same cycle as the clearing write wins.
- R7: A pulse on `fifo_clr_i` empties the FIFO and clears both error bits. A write in the same cycle is discarded. The control register is kept.
- R8: With free space F (64 minus level) and granularity G, the low alarm (status bit 2) is 1 exactly when F > G. G=0 requests until full, and G=1 stops with one word of space left.
- R9: The high alarm (status bit 3) is 1 exactly when F <= G.
- R10: `dreq_o` equals the low alarm when control bit 3 is 0, and the high alarm when it is 1.
- R11: Control bits 3:0 read back as written. Status writes never change the control value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fifo_clr_i | input | 1 | Synchronous FIFO clear (pointers and error bits) |
| wr_en_i | input | 1 | Push request |
| wr_data_i | input | 32 | Word to push |
| rd_en_i | input | 1 | Pop request |
| rd_data_o | output | 32 | Oldest stored word |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 status, 1 control |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| full_o | output | 1 | Live full indication |
| empty_o | output | 1 | Live empty indication |
| dreq_o | output | 1 | Data request toward the requester |

## Verification
Pushes, pops, clears, register writes and error events all take effect at the rising edge that samples them. The status bits, alarms, `dreq_o` and `rd_data_o` are therefore due one edge after the stimulus. The bench drives every input just after a falling edge and compares the results at the next falling edge, half a period after the sampling edge. Register reads are combinational, so the bench sets the address away from any edge and samples 1 ns later. The granularity sweep visits every level from empty to full and back for each of the eight settings. The expected alarms are computed from the free space alone.

// File: rtl/wm_fifo_pkg.sv
package wm_fifo_pkg;
  localparam logic ADDR_STAT = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  localparam int unsigned STAT_EMPTY = 0;
  localparam int unsigned STAT_FULL  = 1;
  localparam int unsigned STAT_LO    = 2;
  localparam int unsigned STAT_HI    = 3;
  localparam int unsigned STAT_OVF   = 4;
  localparam int unsigned STAT_UNF   = 5;
  localparam int unsigned CTRL_RX    = 3;

  // packed MSB first: unf is bit 5, empty is bit 0
  typedef struct packed {
    logic unf;
    logic ovf;
    logic hi;
    logic lo;
    logic full;
    logic empty;
  } stat_t;

  localparam int unsigned STAT_W = $bits(stat_t);
endpackage

// File: rtl/wm_fifo_mem.sv
module wm_fifo_mem #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/wm_fifo_ptr.sv
module wm_fifo_ptr #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] raddr_o,
  output logic          push_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          ovf_evt_o,
  output logic          unf_evt_o
);
  logic [CW-1:0] wptr_q, rptr_q;
  logic          pop;

  // extra wrap bit separates full from empty
  assign empty_o = (wptr_q == rptr_q);
  assign full_o  = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);

  // full/empty judged on the pre-edge state
  assign push_o    = wr_i && !full_o && !clr_i;
  assign pop       = rd_i && !empty_o && !clr_i;
  assign ovf_evt_o = wr_i && full_o;
  assign unf_evt_o = rd_i && empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (push_o) wptr_q <= wptr_q + CW'(1);
      if (pop)    rptr_q <= rptr_q + CW'(1);
    end
  end

  assign waddr_o = wptr_q[AW-1:0];
  assign raddr_o = rptr_q[AW-1:0];
  assign count_o = wptr_q - rptr_q;
endmodule

// File: rtl/wm_fifo_wmark.sv
module wm_fifo_wmark #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned GW    = 3,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input  logic [CW-1:0] count_i,
  input  logic [GW-1:0] gran_i,
  output logic          lo_o,
  output logic          hi_o
);
  logic [CW-1:0] free_words;
  logic [CW-1:0] gran_ext;

  assign free_words = CW'(DEPTH) - count_i;

  generate
    if (CW > GW) begin : g_ext
      assign gran_ext = {{(CW-GW){1'b0}}, gran_i};
    end else begin : g_trunc
      assign gran_ext = gran_i[CW-1:0];
    end
  endgenerate

  // granularity counts free long words
  assign lo_o = (free_words > gran_ext);
  assign hi_o = (free_words <= gran_ext);
endmodule

// File: rtl/wm_fifo_regs.sv
module wm_fifo_regs
  import wm_fifo_pkg::*;
#(
  parameter int unsigned GW = 3,
  parameter int unsigned RW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic          addr_i,
  input  logic [RW-1:0] wdata_i,
  input  logic          ovf_evt_i,
  input  logic          unf_evt_i,
  input  logic          full_i,
  input  logic          empty_i,
  input  logic          lo_i,
  input  logic          hi_i,
  output logic [GW-1:0] gran_o,
  output logic          rx_mode_o,
  output logic          ovf_o,
  output logic          unf_o,
  output logic [RW-1:0] rdata_o
);
  logic  stat_we, ctrl_we;
  stat_t stat;

  assign stat_we = we_i && (addr_i == ADDR_STAT);
  assign ctrl_we = we_i && (addr_i == ADDR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gran_o    <= '0;
      rx_mode_o <= 1'b0;
    end else if (ctrl_we) begin
      gran_o    <= wdata_i[GW-1:0];
      rx_mode_o <= wdata_i[CTRL_RX];
    end
  end

  // sticky, write-1-to-clear; a new event beats the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else if (clr_i) begin
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      ovf_o <= ovf_evt_i || (ovf_o && !(stat_we && wdata_i[STAT_OVF]));
      unf_o <= unf_evt_i || (unf_o && !(stat_we && wdata_i[STAT_UNF]));
    end
  end

  always_comb begin
    stat.unf   = unf_o;
    stat.ovf   = ovf_o;
    stat.hi    = hi_i;
    stat.lo    = lo_i;
    stat.full  = full_i;
    stat.empty = empty_i;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_STAT) begin
      rdata_o[STAT_W-1:0] = stat;
    end else begin
      rdata_o[GW-1:0]  = gran_o;
      rdata_o[CTRL_RX] = rx_mode_o;
    end
  end
endmodule

// File: rtl/wm_fifo.sv
module wm_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned GW    = 3,
  parameter int unsigned RW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_clr_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          reg_we_i,
  input  logic          reg_addr_i,
  input  logic [RW-1:0] reg_wdata_i,
  output logic [RW-1:0] reg_rdata_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          dreq_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] count;
  logic          push, full, empty, ovf_evt, unf_evt;
  logic          lo, hi, ovf, unf, rx_mode;
  logic [GW-1:0] gran;

  wm_fifo_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (fifo_clr_i),
    .wr_i     (wr_en_i),
    .rd_i     (rd_en_i),
    .waddr_o  (waddr),
    .raddr_o  (raddr),
    .push_o   (push),
    .count_o  (count),
    .full_o   (full),
    .empty_o  (empty),
    .ovf_evt_o(ovf_evt),
    .unf_evt_o(unf_evt)
  );

  wm_fifo_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk_i  (clk_i),
    .we_i   (push),
    .waddr_i(waddr),
    .wdata_i(wr_data_i),
    .raddr_i(raddr),
    .rdata_o(rd_data_o)
  );

  wm_fifo_wmark #(.DEPTH(DEPTH), .GW(GW)) u_wmark (
    .count_i(count),
    .gran_i (gran),
    .lo_o   (lo),
    .hi_o   (hi)
  );

  wm_fifo_regs #(.GW(GW), .RW(RW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (fifo_clr_i),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .ovf_evt_i(ovf_evt),
    .unf_evt_i(unf_evt),
    .full_i   (full),
    .empty_i  (empty),
    .lo_i     (lo),
    .hi_i     (hi),
    .gran_o   (gran),
    .rx_mode_o(rx_mode),
    .ovf_o    (ovf),
    .unf_o    (unf),
    .rdata_o  (reg_rdata_o)
  );

  assign full_o  = full;
  assign empty_o = empty;
  assign dreq_o  = rx_mode ? hi : lo;
endmodule

// File: rtl/wm_fifo_chk.sv
module wm_fifo_chk #(
  parameter int unsigned RW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clr_i,
  input logic          wr_i,
  input logic          rd_i,
  input logic          reg_we_i,
  input logic          reg_addr_i,
  input logic [RW-1:0] reg_wdata_i,
  input logic          full_i,
  input logic          empty_i,
  input logic          ovf_i,
  input logic          unf_i,
  input logic          lo_i,
  input logic          hi_i,
  input logic          dreq_i,
  input logic          rx_i
);
  logic clr_ovf_wr, clr_unf_wr;
  assign clr_ovf_wr = reg_we_i && !reg_addr_i && reg_wdata_i[4];
  assign clr_unf_wr = reg_we_i && !reg_addr_i && reg_wdata_i[5];

  assert_full_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_i && empty_i));

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && full_i && !rd_i && !clr_i |=> full_i && ovf_i);

  assert_no_underflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && empty_i && !wr_i && !clr_i |=> empty_i && unf_i);

  assert_ovf_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i && !clr_i && !clr_ovf_wr |=> ovf_i);

  assert_unf_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_i && !clr_i && !clr_unf_wr |=> unf_i);

  assert_fifo_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_i && !ovf_i && !unf_i);

  assert_full_stops_fill_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_i |-> !lo_i && hi_i);

  assert_empty_no_drain_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_i |-> lo_i && !hi_i);

  assert_rx_empty_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_i && empty_i |-> !dreq_i);
endmodule

bind wm_fifo wm_fifo_chk #(.RW(RW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_i      (fifo_clr_i),
  .wr_i       (wr_en_i),
  .rd_i       (rd_en_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .full_i     (full),
  .empty_i    (empty),
  .ovf_i      (ovf),
  .unf_i      (unf),
  .lo_i       (lo),
  .hi_i       (hi),
  .dreq_i     (dreq_o),
  .rx_i       (rx_mode)
);

// File: tb/wm_fifo_tb_top.sv
`timescale 1ns/1ps
module wm_fifo_tb_top;
  localparam int D = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fifo_clr_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        rd_en_i = 1'b0;
  logic [31:0] rd_data_o;
  logic        reg_we_i = 1'b0;
  logic        reg_addr_i = 1'b0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        full_o, empty_o, dreq_o;

  int n_chk = 0;
  int n_err = 0;
  int lvl = 0;
  logic [31:0] mq[$];
  logic [7:0]  rv;
  bit          done = 0;

  always #4 clk_i = ~clk_i;

  wm_fifo dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_stat(int n, int g, bit ov, bit un);
    int fr = D - n;
    return {2'b00, un, ov, fr <= g, fr > g, n == D, n == 0};
  endfunction

  task automatic cyc(input bit wr, input logic [31:0] d, input bit rd);
    wr_en_i = wr; wr_data_i = d; rd_en_i = rd;
    @(negedge clk_i);
    wr_en_i = 0; rd_en_i = 0;
  endtask

  task automatic push(input logic [31:0] d);
    cyc(1, d, 0); mq.push_back(d); lvl++;
  endtask

  task automatic pop_chk(input string req);
    chk(req, rd_data_o, mq[0]);
    cyc(0, 0, 1); void'(mq.pop_front()); lvl--;
  endtask

  task automatic reg_wr(input logic a, input logic [7:0] d);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 0;
  endtask

  task automatic reg_rd(input logic a, output logic [7:0] d);
    reg_addr_i = a; #1; d = reg_rdata_o;
  endtask

  task automatic clear_all();
    fifo_clr_i = 1; @(negedge clk_i); fifo_clr_i = 0;
    mq.delete(); lvl = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R1 reset state
    reg_rd(0, rv); chk("R1 status", rv, 8'h05);
    reg_rd(1, rv); chk("R1 control", rv, 8'h00);
    chk("R1 dreq", dreq_o, 1);

    // R3 R8 R9 R10 sweep every granularity over every level
    for (int g = 0; g < 8; g++) begin
      reg_wr(1, 8'(g));
      reg_rd(1, rv); chk("R11 ctrl readback", rv, 8'(g));
      for (int i = 0; i < D; i++) begin
        push(32'(g * 256 + i));
        reg_rd(0, rv); chk("R8 R9 fill status", rv, exp_stat(lvl, g, 0, 0));
        chk("R3 full_o", full_o, lvl == D);
        chk("R10 tx dreq", dreq_o, (D - lvl) > g);
      end
      for (int i = 0; i < D; i++) begin
        pop_chk("R2 order");
        reg_rd(0, rv); chk("R3 drain status", rv, exp_stat(lvl, g, 0, 0));
        chk("R3 empty_o", empty_o, lvl == 0);
      end
    end

    // R10 receive mode
    reg_wr(1, 8'h0A);
    reg_rd(1, rv); chk("R11 rx readback", rv, 8'h0A);
    for (int i = 0; i < D; i++) begin
      push(32'h1000 + 32'(i));
      chk("R10 rx dreq", dreq_o, (D - lvl) <= 2);
    end
    reg_wr(0, 8'h00);
    reg_rd(1, rv); chk("R11 status write keeps ctrl", rv, 8'h0A);
    clear_all();
    reg_wr(1, 8'h00);

    // R2 simultaneous push/pop keeps level
    push(32'hA1); push(32'hA2);
    chk("R2 head", rd_data_o, 32'hA1);
    cyc(1, 32'hA3, 1); void'(mq.pop_front()); mq.push_back(32'hA3);
    reg_rd(0, rv); chk("R2 level kept", rv, exp_stat(2, 0, 0, 0));
    pop_chk("R2 head after rw"); pop_chk("R2 tail");

    // R5 underflow
    cyc(0, 0, 1);
    reg_rd(0, rv); chk("R5 underflow set", rv, exp_stat(0, 0, 0, 1));
    cyc(1, 32'hB0, 1); mq.push_back(32'hB0); lvl = 1;
    reg_rd(0, rv); chk("R5 write kept on empty read", rv, exp_stat(1, 0, 0, 1));
    chk("R5 data", rd_data_o, 32'hB0);
    pop_chk("R5 drain");

    // R4 overflow
    for (int i = 0; i < D; i++) push(32'hC000 + 32'(i));
    cyc(1, 32'hDEAD, 0);
    reg_rd(0, rv); chk("R4 overflow set", rv, exp_stat(D, 0, 1, 1));
    cyc(1, 32'hBEEF, 1); void'(mq.pop_front()); lvl--;
    reg_rd(0, rv); chk("R4 rw on full", rv, exp_stat(D - 1, 0, 1, 1));
    chk("R4 full_o", full_o, 0);
    for (int i = 0; i < D - 1; i++) pop_chk("R4 data intact");
    chk("R4 empty after drain", empty_o, 1);

    // R6 write-1-to-clear
    repeat (3) @(negedge clk_i);
    reg_rd(0, rv); chk("R6 sticky idle", rv, exp_stat(0, 0, 1, 1));
    reg_wr(0, 8'h00);
    reg_rd(0, rv); chk("R6 zero write", rv, exp_stat(0, 0, 1, 1));
    reg_wr(0, 8'h10);
    reg_rd(0, rv); chk("R6 clear ovf only", rv, exp_stat(0, 0, 0, 1));
    reg_we_i = 1; reg_addr_i = 0; reg_wdata_i = 8'h20; rd_en_i = 1;
    @(negedge clk_i);
    reg_we_i = 0; rd_en_i = 0;
    reg_rd(0, rv); chk("R6 set wins", rv, exp_stat(0, 0, 0, 1));
    reg_wr(0, 8'h20);
    reg_rd(0, rv); chk("R6 clear unf", rv, exp_stat(0, 0, 0, 0));

    // R7 FIFO clear
    reg_wr(1, 8'h05);
    for (int i = 0; i < D; i++) push(32'(i));
    cyc(1, 0, 0);
    cyc(0, 0, 0);
    wr_en_i = 1; wr_data_i = 32'h77; fifo_clr_i = 1;
    @(negedge clk_i);
    wr_en_i = 0; fifo_clr_i = 0; mq.delete(); lvl = 0;
    reg_rd(0, rv); chk("R7 cleared", rv, exp_stat(0, 5, 0, 0));
    chk("R7 empty_o", empty_o, 1);
    reg_rd(1, rv); chk("R7 ctrl kept", rv, 8'h05);
    push(32'h55);
    chk("R7 fresh head", rd_data_o, 32'h55);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule